// File: doc/BRIEF.md
# Sequential Palette Loader

This block holds a colour lookup table of 256 entries, each a red, green and blue byte, and fills it through two registers on a small byte-addressed write bus. Software first writes an entry number to the index register, then streams colour bytes into the data register. Each byte lands in the next component of the current entry, cycling red, green, blue. Once blue is stored, the entry number steps on by one. A whole table can therefore be loaded with one index write followed by a run of data writes.

A data write is either a single byte, taken from the low byte of the write data, or a full 32-bit word. A word is split into four component bytes, most significant first, and stored over four clock cycles. While the last three are stored, a busy output tells the bus to hold off. Display logic reads colours through a separate lookup port: it presents a pixel value and gets the 24-bit colour one cycle later. Every accepted data write raises a one-cycle "palette changed" pulse, which the display uses to schedule a full redraw. Register reads return zero.

Top module: `pal_loader`

## Requirements
- R1: While reset is low at a clock edge, every entry is cleared to 0x000000, the entry number becomes 0, the component phase returns to red, and busy, the change pulse and the lookup output are all low after that edge.
- R2: A write to offset 0x0 loads wdata[7:0] as the entry number and sets the phase to red, even if only part of an entry has been written.
- R3: A single-byte write to offset 0x4 (bus_wide = 0) stores wdata[7:0] into red, green or blue of the current entry, in that order, with the phase returning to red after blue. wdata[31:8] is ignored.
- R4: Storing the blue component advances the entry number by one, and entry 255 wraps to entry 0.
- R5: A word write to offset 0x4 (bus_wide = 1) stores wdata[31:24], [23:16], [15:8] and [7:0] as four consecutive components, one per cycle, starting in the accepting cycle. Busy is high for exactly the three cycles after acceptance.
- R6: Any write presented while busy is high is dropped: it changes neither the entry number, the phase nor any entry, and it raises no change pulse.
- R7: The change pulse is high for exactly the one cycle after each accepted write to offset 0x4, and is low otherwise.
- R8: The lookup output shows {red, green, blue} (red in bits 23:16) of the entry selected by the pixel index at the previous clock edge, as the table stood before that edge.
- R9: The register read data is always zero.
- R10: A write to any offset other than 0x0 and 0x4 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Byte offset of the register written |
| bus_wdata | input | 32 | Write data |
| bus_wide | input | 1 | 1 for a 32-bit data write, 0 for a single byte |
| bus_busy | output | 1 | High while a word write is still being unpacked |
| bus_rdata | output | 32 | Register read data, always zero |
| pix_idx | input | 8 | Pixel value to look up |
| pix_rgb | output | 24 | Colour of the looked-up entry |
| pal_changed | output | 1 | One-cycle pulse after each accepted data write |

## Verification
The hardest situation to reach is a write that arrives while a word write is still being unpacked, especially when the phase is partway through an entry and the entry number is about to wrap. Such a write must leave no trace. The bench forces this case directly. It issues index and data writes in the cycles right after a word write, and then shows that the next byte continues the interrupted phase. It also runs a long random stream in which word writes, byte writes and stray offsets overlap busy windows freely. Throughout, a behavioural model that queues the pending bytes is compared with the block's outputs.

// File: rtl/pal_pkg.sv
// Package: shared constants and the component-phase type for the palette loader.
// Assumes three colour components stored in red, green, blue order.
package pal_pkg;

    localparam int NUM_COMP = 3;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    // Next phase in the red -> green -> blue cycle
    function automatic phase_e phase_next(input phase_e p);
        case (p)
            PH_RED:  phase_next = PH_GRN;
            PH_GRN:  phase_next = PH_BLU;
            default: phase_next = PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/pal_seq.sv
// Module: pal_seq
// Decodes bus writes, keeps the entry number and component phase, and unpacks
// word writes into one component byte per cycle. Assumes the bus master holds
// off while busy is high; writes seen while busy are dropped.
module pal_seq
    import pal_pkg::*;
#(
    parameter int ENTRIES  = 256,
    parameter int COMP_W   = 8,
    parameter int BUS_W    = 32,
    parameter int ADDR_W   = 3,
    parameter int IDX_OFS  = 0,
    parameter int DATA_OFS = 4,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int LANES   = BUS_W / COMP_W,
    localparam int RW      = $clog2(LANES),
    localparam int SH_W    = BUS_W - COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              wide,
    output logic              busy,
    output logic              comp_we,
    output phase_e            comp_sel,
    output logic [IDX_W-1:0]  comp_idx,
    output logic [COMP_W-1:0] comp_byte,
    output logic              changed
);

    logic [IDX_W-1:0] idx_q;
    phase_e           phase_q;
    logic [SH_W-1:0]  shift_q;
    logic [RW-1:0]    remain_q;
    logic             idx_acc;
    logic             data_acc;

    assign busy     = (remain_q != '0);
    assign idx_acc  = wr && !busy && (addr == ADDR_W'(IDX_OFS));
    assign data_acc = wr && !busy && (addr == ADDR_W'(DATA_OFS));

    // Select the component byte to store this cycle
    always_comb begin
        comp_we   = 1'b0;
        comp_byte = '0;
        if (busy) begin
            comp_we   = 1'b1;
            comp_byte = shift_q[SH_W-1 -: COMP_W];
        end else if (data_acc) begin
            comp_we   = 1'b1;
            comp_byte = wide ? wdata[BUS_W-1 -: COMP_W] : wdata[COMP_W-1:0];
        end
    end

    assign comp_sel = phase_q;
    assign comp_idx = idx_q;

    // Advance phase, entry number and unpack state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            phase_q  <= PH_RED;
            shift_q  <= '0;
            remain_q <= '0;
            changed  <= 1'b0;
        end else begin
            changed <= data_acc;
            if (idx_acc) begin
                idx_q   <= wdata[IDX_W-1:0];
                phase_q <= PH_RED;
            end else if (comp_we) begin
                phase_q <= phase_next(phase_q);
                if (phase_q == PH_BLU) begin
                    idx_q <= (idx_q == IDX_W'(ENTRIES-1)) ? '0 : idx_q + 1'b1;
                end
            end
            if (busy) begin
                shift_q  <= shift_q << COMP_W;
                remain_q <= remain_q - 1'b1;
            end else if (data_acc && wide) begin
                shift_q  <= wdata[SH_W-1:0];
                remain_q <= RW'(LANES-1);
            end
        end
    end

endmodule

// File: rtl/pal_store.sv
// Module: pal_store
// Holds one flop array per colour component and a registered lookup port.
// Assumes at most one component write per cycle; lookup sees the table as it
// stood before the current edge.
module pal_store
    import pal_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int COMP_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  phase_e                     sel,
    input  logic [IDX_W-1:0]           widx,
    input  logic [COMP_W-1:0]          wbyte,
    input  logic [IDX_W-1:0]           ridx,
    output logic [NUM_COMP*COMP_W-1:0] rgb
);

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
        logic [COMP_W-1:0] mem [ENTRIES];

        // Clear on reset, otherwise store this component's byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
            end else if (we && (sel == phase_e'(c))) begin
                mem[widx] <= wbyte;
            end
        end

        // Registered lookup; red lands in the top byte
        always_ff @(posedge clk) begin
            if (!rst_n) rgb[(NUM_COMP-1-c)*COMP_W +: COMP_W] <= '0;
            else        rgb[(NUM_COMP-1-c)*COMP_W +: COMP_W] <= mem[ridx];
        end
    end

endmodule

// File: rtl/pal_loader.sv
// Module: pal_loader (top)
// Palette loader: index register and colour data register on a byte-offset
// write bus, plus a one-cycle-latency colour lookup port. Assumes the bus
// master respects bus_busy; register reads carry no state.
module pal_loader
    import pal_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int COMP_W  = 8,
    parameter int BUS_W   = 32,
    parameter int ADDR_W  = 3,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int RGB_W  = NUM_COMP * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_wide,
    output logic              bus_busy,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [RGB_W-1:0]  pix_rgb,
    output logic              pal_changed
);

    logic              we;
    phase_e            sel;
    logic [IDX_W-1:0]  widx;
    logic [COMP_W-1:0] wbyte;

    // Neither register holds readable state
    assign bus_rdata = '0;

    pal_seq #(
        .ENTRIES (ENTRIES),
        .COMP_W  (COMP_W),
        .BUS_W   (BUS_W),
        .ADDR_W  (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .wide      (bus_wide),
        .busy      (bus_busy),
        .comp_we   (we),
        .comp_sel  (sel),
        .comp_idx  (widx),
        .comp_byte (wbyte),
        .changed   (pal_changed)
    );

    pal_store #(
        .ENTRIES (ENTRIES),
        .COMP_W  (COMP_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .sel   (sel),
        .widx  (widx),
        .wbyte (wbyte),
        .ridx  (pix_idx),
        .rgb   (pix_rgb)
    );

endmodule

// File: rtl/pal_loader_chk.sv
// Module: pal_loader_chk
// Checker for the palette loader's bus-side timing, bound to pal_loader.
// Assumes the data register sits at offset 4.
module pal_loader_chk #(
    parameter int ADDR_W = 3,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wide,
    input logic              bus_busy,
    input logic              pal_changed
);

    logic data_acc;
    int   run_q;

    assign data_acc = bus_wr && !bus_busy && (bus_addr == ADDR_W'(4));

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= 0;
        else if (bus_busy) run_q <= run_q + 1;
        else               run_q <= 0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!bus_busy && !pal_changed));

    // R5
    wide_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && bus_wide) |=> bus_busy);

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && $past(bus_busy)) |-> (run_q == LANES-1));

    // R7
    pulse_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc |=> pal_changed);

    // R7
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_changed |-> $past(data_acc));

    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> !pal_changed);

endmodule

bind pal_loader pal_loader_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (BUS_W / COMP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wide    (bus_wide),
    .bus_busy    (bus_busy),
    .pal_changed (pal_changed)
);

// File: tb/tb_pal_loader.sv
// Bench: behavioural model of the palette (arrays plus a queue of pending
// bytes) compared with the outputs every clock, plus directed scenario checks.
module tb_pal_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wide = 1'b0;
    logic        bus_busy;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;
    logic        pal_changed;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference model state
    logic [7:0]  mr [256];
    logic [7:0]  mg [256];
    logic [7:0]  mb [256];
    logic [7:0]  m_idx;
    int          m_ph;
    logic [7:0]  pendq [$];
    logic [23:0] e_rgb;
    logic        e_chg;

    always #5 clk = ~clk;

    pal_loader dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_wide    (bus_wide),
        .bus_busy    (bus_busy),
        .bus_rdata   (bus_rdata),
        .pix_idx     (pix_idx),
        .pix_rgb     (pix_rgb),
        .pal_changed (pal_changed)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_store(input logic [7:0] b);
        case (m_ph)
            0: mr[m_idx] = b;
            1: mg[m_idx] = b;
            default: begin
                mb[m_idx] = b;
                m_idx = m_idx + 8'd1;
            end
        endcase
        m_ph = (m_ph + 1) % 3;
    endtask

    // One clock: drive, advance model at the edge, compare after it
    task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] d,
                        input logic w, input logic [7:0] p);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; bus_wide = w; pix_idx = p;
        @(posedge clk);
        e_chg = 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin mr[i] = 0; mg[i] = 0; mb[i] = 0; end
            m_idx = 0; m_ph = 0; pendq.delete(); e_rgb = 0;
        end else begin
            e_rgb = {mr[p], mg[p], mb[p]};
            if (pendq.size() > 0) begin
                m_store(pendq.pop_front());
            end else if (wr && a == 3'd0) begin
                m_idx = d[7:0]; m_ph = 0;
            end else if (wr && a == 3'd4) begin
                e_chg = 1'b1;
                if (w) begin
                    m_store(d[31:24]);
                    pendq.push_back(d[23:16]);
                    pendq.push_back(d[15:8]);
                    pendq.push_back(d[7:0]);
                end else begin
                    m_store(d[7:0]);
                end
            end
        end
        #1;
        chk(pix_rgb === e_rgb, "R8 lookup vs model", {8'h0, pix_rgb}, {8'h0, e_rgb});
        chk(bus_busy === (pendq.size() > 0), "R5 busy vs model", {31'h0, bus_busy}, {31'h0, pendq.size() > 0});
        chk(pal_changed === e_chg, "R7 change pulse vs model", {31'h0, pal_changed}, {31'h0, e_chg});
        chk(bus_rdata === 32'h0, "R9 read data", bus_rdata, 32'h0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'h0, 1'b0, 8'h0);
    endtask

    task automatic wr_idx(input logic [7:0] v);
        step(1'b1, 3'd0, {24'h0, v}, 1'b0, 8'h0);
    endtask

    task automatic wr_byte(input logic [31:0] v);
        step(1'b1, 3'd4, v, 1'b0, 8'h0);
    endtask

    task automatic lookup(input logic [7:0] p, input logic [23:0] exp, input string tag);
        step(1'b0, 3'd0, 32'h0, 1'b0, p);
        chk(pix_rgb === exp, tag, {8'h0, pix_rgb}, {8'h0, exp});
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset clears the table and quiets the outputs
        rst_n = 1'b0;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        chk(bus_busy === 1'b0, "R1 busy after reset", {31'h0, bus_busy}, 32'h0);
        chk(pal_changed === 1'b0, "R1 pulse after reset", {31'h0, pal_changed}, 32'h0);
        lookup(8'd0, 24'h0, "R1 entry 0 cleared");
        lookup(8'd255, 24'h0, "R1 entry 255 cleared");

        // R3: byte order, low byte used, phase wraps into next entry
        wr_idx(8'd5);
        wr_byte(32'h0000_0011);
        chk(pal_changed === 1'b1, "R7 pulse after byte write", {31'h0, pal_changed}, 32'h1);
        wr_byte(32'hFFFF_FF22);
        wr_byte(32'h0000_0033);
        wr_byte(32'hABCD_EF44);
        lookup(8'd5, 24'h112233, "R3 entry 5 components");
        chk(pal_changed === 1'b0, "R7 pulse lasts one cycle", {31'h0, pal_changed}, 32'h0);
        lookup(8'd6, 24'h440000, "R3 next entry red");

        // R2: index write mid-entry restarts at red
        wr_idx(8'd10);
        chk(pal_changed === 1'b0, "R7 no pulse for index write", {31'h0, pal_changed}, 32'h0);
        wr_byte(32'h01);
        wr_byte(32'h02);
        wr_idx(8'd12);
        wr_byte(32'h07);
        wr_byte(32'h08);
        wr_byte(32'h09);
        lookup(8'd12, 24'h070809, "R2 phase reset to red");
        lookup(8'd10, 24'h010200, "R2 partial entry kept");

        // R4: wrap from entry 255 to entry 0
        wr_idx(8'd255);
        wr_byte(32'hAA);
        wr_byte(32'hBB);
        wr_byte(32'hCC);
        wr_byte(32'hDD);
        lookup(8'd255, 24'hAABBCC, "R4 entry 255");
        lookup(8'd0, 24'hDD0000, "R4 wrapped to entry 0");

        // R5: word write unpacked MSB first with three busy cycles
        wr_idx(8'd20);
        step(1'b1, 3'd4, 32'hAABB_CCDD, 1'b1, 8'h0);
        chk(bus_busy === 1'b1, "R5 busy after word write", {31'h0, bus_busy}, 32'h1);
        // R6: index and data writes during busy are dropped
        step(1'b1, 3'd0, 32'h40, 1'b0, 8'h0);
        step(1'b1, 3'd4, 32'h99, 1'b1, 8'h0);
        chk(bus_busy === 1'b1, "R5 busy third cycle", {31'h0, bus_busy}, 32'h1);
        chk(pal_changed === 1'b0, "R6 no pulse while busy", {31'h0, pal_changed}, 32'h0);
        step(1'b1, 3'd4, 32'h98, 1'b0, 8'h0);
        chk(bus_busy === 1'b0, "R5 busy ends", {31'h0, bus_busy}, 32'h0);
        lookup(8'd20, 24'hAABBCC, "R5 word components");
        lookup(8'd21, 24'hDD0000, "R5 fourth byte to next red");
        lookup(8'd64, 24'h000000, "R6 dropped index write");
        wr_byte(32'h55);
        lookup(8'd21, 24'hDD5500, "R6 phase kept after busy");

        // R10: unknown offset changes nothing
        step(1'b1, 3'd2, 32'h77, 1'b0, 8'h0);
        chk(pal_changed === 1'b0, "R10 no pulse", {31'h0, pal_changed}, 32'h0);
        wr_byte(32'h66);
        lookup(8'd21, 24'hDD5566, "R10 stray write ignored");

        // Random mix, including writes that overlap busy windows
        for (int i = 0; i < 3000; i++) begin
            int sel;
            logic [2:0] a;
            sel = $urandom_range(0, 9);
            a = (sel < 2) ? 3'd0 : (sel < 9) ? 3'd4 : 3'd6;
            step($urandom_range(0, 3) != 0, a, $urandom, $urandom_range(0, 2) == 0,
                 8'($urandom_range(0, 255)));
        end
        idle(4);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule